// File: doc/BRIEF.md
# Open-Drain Line Repeater

This block joins two open-drain data lines, one facing the host and one facing the card. Both lines rest high through passive pullups and neither side is driven while nothing happens. Whichever line is seen to fall first becomes the master for that transfer. After a fixed delay the repeater pulls the other line, the slave, low. While the master stays low, falling edges on the slave are ignored. When the master rises again, the repeater lets go of the slave and drives a short active pullup on it to speed the rising edge. It then returns to the passive state and waits for the next falling edge on either side.

The block runs on a fast system clock. Its inputs are the sampled levels of the two lines, each passed through its own synchronizer, and an enable from the session sequencer. Its outputs are a pull-low enable and a pullup enable for each side. While the enable is low, the card line is held low and the host line is left alone. The edge delay and the pullup pulse width are parameters counted in clock cycles. The expected line toggle rate is at most 1 MHz.

Top module: `od_line_repeater`

## Requirements
- R1: While reset is asserted, all four drive outputs are 0.
- R2: With the enable high and both lines high, no drive output is asserted.
- R3: Counting the first rising clock edge that samples the master line low as edge 0, the slave pull-low output becomes 1 after edge EDGE_DLY+3. It stays 1 until the master is released. With the defaults (EDGE_DLY=4, SYNC_STAGES=2), the slave pull-low is first seen after edge 7.
- R4: Counting the first edge that samples the master high again as edge 0, the slave pull-low drops and the slave pullup rises after edge 3. The pullup stays 1 for exactly PU_CYC cycles, after which all drives are 0.
- R5: The block is symmetric. A card-side master causes the host pull-low and host pullup to be driven with the same timing as in R3 and R4, and the card-side drives stay 0.
- R6: While a transfer is in progress, a low level applied from outside on the slave line does not cause any drive on the master side.
- R7: If both lines are first seen low on the same clock edge, the host side becomes master. The host-side drives stay 0, and the host and card pull-low outputs are never both 1.
- R8: If the master low lasts EDGE_DLY sampled edges or fewer, nothing is forwarded and no pullup is driven. A low of EDGE_DLY+1 edges is forwarded for one cycle.
- R9: Take the edge that samples the enable low as edge 0. After edge 1 the card pull-low is 1 and every other drive is 0. This aborts any transfer in progress, and activity on the host line has no effect while the enable stays low.
- R10: After the pullup pulse, or after the enable returns high, arbitration is re-armed, so a following transfer may take either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sessEn | input | 1 | Session enable from the sequencer |
| hostLine | input | 1 | Sampled level of the host-side line |
| cardLine | input | 1 | Sampled level of the card-side line |
| hostPullLow | output | 1 | Turns on the host-side pull-down |
| hostPullUp | output | 1 | Turns on the host-side active pullup |
| cardPullLow | output | 1 | Turns on the card-side pull-down |
| cardPullUp | output | 1 | Turns on the card-side active pullup |

## Verification
Two cases can land in the same cycle. In the first, falling edges on both sides reach the arbiter together. The bench provokes this by dropping both external lines on the same clock half, then confirms that only the card pull-low appears, at the R3 edge, and that the host drives stay silent. In the second, a slave-side fall arrives while a transfer is already in progress. The bench provokes this by pulling the slave line low during the hold phase, then checks that the master side is never driven and that the pullup pulse still has its exact length. Random transfers in both directions, with low lengths straddling the forwarding threshold, are compared against counts computed by bench functions.

// File: rtl/od_rpt_pkg.sv
package od_rpt_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_IDLE,
    ST_DELAY,
    ST_HOLD,
    ST_PULSE
  } rptState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDelay;   // arm timer with edge delay
    logic loadPulse;   // arm timer with pullup width
    logic cardIsSlave; // direction of the current transfer
    logic driveLow;    // pull slave low
    logic drivePu;     // active pullup on slave
    logic offMode;     // sequencer disabled: hold card low
  } rptCtl_t;

endpackage

// File: rtl/rpt_datapath.sv
module rpt_datapath
  import od_rpt_pkg::*;
#(
  parameter int EDGE_DLY    = 4,
  parameter int PU_CYC      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostLine,
  input  logic    cardLine,
  input  rptCtl_t ctl,
  output logic    hostSync,
  output logic    cardSync,
  output logic    hostFall,
  output logic    cardFall,
  output logic    timerDone,
  output logic    hostPullLow,
  output logic    hostPullUp,
  output logic    cardPullLow,
  output logic    cardPullUp
);

  localparam int MAX_CNT = (EDGE_DLY > PU_CYC) ? EDGE_DLY : PU_CYC;
  localparam int TW      = $clog2(MAX_CNT + 1);
  localparam int NSIDE   = 2;

  logic [NSIDE-1:0] lineIn;
  logic [NSIDE-1:0] syncV;
  logic [NSIDE-1:0] fallV;

  assign lineIn = {cardLine, hostLine};

  // per-side synchronizer and falling-edge detector
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    logic [SYNC_STAGES-1:0] chain;
    logic                   prevQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain <= '1;
        prevQ <= 1'b1;
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], lineIn[s]};
        prevQ <= chain[SYNC_STAGES-1];
      end
    end
    assign syncV[s] = chain[SYNC_STAGES-1];
    assign fallV[s] = prevQ & ~chain[SYNC_STAGES-1];
  end

  assign hostSync = syncV[0];
  assign cardSync = syncV[1];
  assign hostFall = fallV[0];
  assign cardFall = fallV[1];

  // shared down-counter for edge delay and pullup pulse
  logic [TW-1:0] timerQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timerQ <= '0;
    else if (ctl.loadDelay) timerQ <= TW'(EDGE_DLY - 1);
    else if (ctl.loadPulse) timerQ <= TW'(PU_CYC - 1);
    else if (timerQ != '0)  timerQ <= timerQ - 1'b1;
  end
  assign timerDone = (timerQ == '0);

  // registered pin drives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostPullLow <= 1'b0;
      hostPullUp  <= 1'b0;
      cardPullLow <= 1'b0;
      cardPullUp  <= 1'b0;
    end else begin
      cardPullLow <= ctl.offMode | (ctl.driveLow & ctl.cardIsSlave);
      hostPullLow <= ~ctl.offMode & ctl.driveLow & ~ctl.cardIsSlave;
      cardPullUp  <= ~ctl.offMode & ctl.drivePu & ctl.cardIsSlave;
      hostPullUp  <= ~ctl.offMode & ctl.drivePu & ~ctl.cardIsSlave;
    end
  end

  // pullup run-length counters for checking
  logic [TW:0] puRunHost, puRunCard;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      puRunHost <= '0;
      puRunCard <= '0;
    end else begin
      puRunHost <= hostPullUp ? puRunHost + 1'b1 : '0;
      puRunCard <= cardPullUp ? puRunCard + 1'b1 : '0;
    end
  end

  AST_PU_LEN_HOST: assert property (@(posedge clk) disable iff (!rstN)
    puRunHost <= (TW+1)'(PU_CYC)); // R4
  AST_PU_LEN_CARD: assert property (@(posedge clk) disable iff (!rstN)
    puRunCard <= (TW+1)'(PU_CYC)); // R4
  AST_PU_AFTER_LOW_CARD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardPullUp) |-> $past(cardPullLow)); // R4
  AST_PU_AFTER_LOW_HOST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostPullUp) |-> $past(hostPullLow)); // R5

endmodule

// File: rtl/rpt_control.sv
module rpt_control
  import od_rpt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sessEn,
  input  logic    hostSync,
  input  logic    cardSync,
  input  logic    hostFall,
  input  logic    cardFall,
  input  logic    timerDone,
  output rptCtl_t ctl
);

  rptState_t stateQ, stateD;
  logic      cardMasterQ, cardMasterD;
  logic      masterHigh;
  logic      loadDelay, loadPulse;

  assign masterHigh = cardMasterQ ? cardSync : hostSync;

  always_comb begin
    stateD      = stateQ;
    cardMasterD = cardMasterQ;
    loadDelay   = 1'b0;
    loadPulse   = 1'b0;
    case (stateQ)
      ST_OFF:   if (sessEn) stateD = ST_IDLE;
      ST_IDLE: begin
        // host wins a tie
        if (hostFall) begin
          stateD      = ST_DELAY;
          cardMasterD = 1'b0;
          loadDelay   = 1'b1;
        end else if (cardFall) begin
          stateD      = ST_DELAY;
          cardMasterD = 1'b1;
          loadDelay   = 1'b1;
        end
      end
      ST_DELAY: begin
        if (masterHigh)     stateD = ST_IDLE;
        else if (timerDone) stateD = ST_HOLD;
      end
      ST_HOLD: begin
        if (masterHigh) begin
          stateD    = ST_PULSE;
          loadPulse = 1'b1;
        end
      end
      ST_PULSE: if (timerDone) stateD = ST_IDLE;
      default:  stateD = ST_OFF;
    endcase
    if (!sessEn) begin
      stateD    = ST_OFF;
      loadDelay = 1'b0;
      loadPulse = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= ST_OFF;
      cardMasterQ <= 1'b0;
    end else begin
      stateQ      <= stateD;
      cardMasterQ <= cardMasterD;
    end
  end

  always_comb begin
    ctl             = '0;
    ctl.loadDelay   = loadDelay;
    ctl.loadPulse   = loadPulse;
    ctl.cardIsSlave = ~cardMasterQ;
    ctl.driveLow    = (stateQ == ST_HOLD);
    ctl.drivePu     = (stateQ == ST_PULSE);
    ctl.offMode     = (stateQ == ST_OFF);
  end

  logic busy;
  assign busy = (stateQ == ST_DELAY) || (stateQ == ST_HOLD) || (stateQ == ST_PULSE);

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cardMasterQ)); // R6
  AST_HOLD_ONLY_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD && $past(stateQ) != ST_HOLD) |-> $past(stateQ) == ST_DELAY); // R3

endmodule

// File: rtl/od_line_repeater.sv
module od_line_repeater
  import od_rpt_pkg::*;
#(
  parameter int EDGE_DLY    = 4,
  parameter int PU_CYC      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sessEn,
  input  logic hostLine,
  input  logic cardLine,
  output logic hostPullLow,
  output logic hostPullUp,
  output logic cardPullLow,
  output logic cardPullUp
);

  rptCtl_t ctl;
  logic    hostSync, cardSync, hostFall, cardFall, timerDone;

  rpt_control i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sessEn    (sessEn),
    .hostSync  (hostSync),
    .cardSync  (cardSync),
    .hostFall  (hostFall),
    .cardFall  (cardFall),
    .timerDone (timerDone),
    .ctl       (ctl)
  );

  rpt_datapath #(
    .EDGE_DLY    (EDGE_DLY),
    .PU_CYC      (PU_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .hostLine    (hostLine),
    .cardLine    (cardLine),
    .ctl         (ctl),
    .hostSync    (hostSync),
    .cardSync    (cardSync),
    .hostFall    (hostFall),
    .cardFall    (cardFall),
    .timerDone   (timerDone),
    .hostPullLow (hostPullLow),
    .hostPullUp  (hostPullUp),
    .cardPullLow (cardPullLow),
    .cardPullUp  (cardPullUp)
  );

  AST_NEVER_BOTH_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !(hostPullLow && cardPullLow)); // R7
  AST_OFF_HOLDS_CARD: assert property (@(posedge clk) disable iff (!rstN)
    !sessEn |-> ##2 (cardPullLow && !hostPullLow && !hostPullUp && !cardPullUp)); // R9

endmodule

// File: tb/test_od_line_repeater.sv
module test_od_line_repeater;

  localparam int D = 4;
  localparam int P = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sessEn = 1'b0;
  logic hostExt = 1'b1;
  logic cardExt = 1'b1;
  logic hostLine, cardLine;
  logic hostPullLow, hostPullUp, cardPullLow, cardPullUp;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  assign hostLine = hostExt & ~hostPullLow;
  assign cardLine = cardExt & ~cardPullLow;

  od_line_repeater #(.EDGE_DLY(D), .PU_CYC(P), .SYNC_STAGES(2)) i_od_line_repeater (
    .clk(clk), .rstN(rstN), .sessEn(sessEn),
    .hostLine(hostLine), .cardLine(cardLine),
    .hostPullLow(hostPullLow), .hostPullUp(hostPullUp),
    .cardPullLow(cardPullLow), .cardPullUp(cardPullUp)
  );

  task automatic checkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit fwd(int lowLen);
    return lowLen > D;
  endfunction
  function automatic int expFirstLow(int lowLen);
    return fwd(lowLen) ? D + 4 : 0;
  endfunction
  function automatic int expLowCnt(int lowLen);
    return fwd(lowLen) ? lowLen - D : 0;
  endfunction
  function automatic int expFirstPu(int lowLen);
    return fwd(lowLen) ? lowLen + 4 : 0;
  endfunction
  function automatic int expPuCnt(int lowLen);
    return fwd(lowLen) ? P : 0;
  endfunction

  // one transfer; called at a negedge
  task automatic runXfer(bit cardMaster, int lowLen, bit both, bit inject, string req);
    int firstLow = 0, lowCnt = 0, firstPu = 0, puCnt = 0, masterDrv = 0;
    int total = lowLen + P + 8;
    if (cardMaster) cardExt = 1'b0; else hostExt = 1'b0;
    if (both) cardExt = 1'b0;
    for (int n = 1; n <= total; n++) begin
      @(negedge clk);
      if (cardMaster) begin
        if (hostPullLow) begin lowCnt++; if (firstLow == 0) firstLow = n; end
        if (hostPullUp)  begin puCnt++;  if (firstPu == 0)  firstPu = n;  end
        if (cardPullLow || cardPullUp) masterDrv++;
      end else begin
        if (cardPullLow) begin lowCnt++; if (firstLow == 0) firstLow = n; end
        if (cardPullUp)  begin puCnt++;  if (firstPu == 0)  firstPu = n;  end
        if (hostPullLow || hostPullUp) masterDrv++;
      end
      if (inject && n == D + 6) begin if (cardMaster) hostExt = 1'b0; else cardExt = 1'b0; end
      if (inject && n == D + 9) begin if (cardMaster) hostExt = 1'b1; else cardExt = 1'b1; end
      if (n == lowLen) begin
        if (cardMaster) cardExt = 1'b1; else hostExt = 1'b1;
        if (both) cardExt = 1'b1;
      end
    end
    checkEq(req, "first slave pull-low index", firstLow, expFirstLow(lowLen));
    checkEq(req, "slave pull-low cycles", lowCnt, expLowCnt(lowLen));
    checkEq(req, "first slave pullup index", firstPu, expFirstPu(lowLen));
    checkEq(req, "slave pullup cycles", puCnt, expPuCnt(lowLen));
    checkEq(req, "master side drive cycles", masterDrv, 0);
  endtask

  task automatic checkIdle(string req, int cyc);
    int drv = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (hostPullLow || hostPullUp || cardPullLow || cardPullUp) drv++;
    end
    checkEq(req, "drive cycles while idle", drv, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    // R1 reset state
    repeat (3) @(negedge clk);
    checkEq("R1", "drives in reset",
            int'({hostPullLow, hostPullUp, cardPullLow, cardPullUp}), 0);
    rstN = 1'b1;
    // R9 disabled after reset: card held low
    repeat (2) @(negedge clk);
    checkEq("R9", "card pull-low while disabled", int'(cardPullLow), 1);
    checkEq("R9", "host drives while disabled", int'({hostPullLow, hostPullUp}), 0);
    sessEn = 1'b1;
    repeat (2) @(negedge clk);
    checkEq("R10", "card released after enable", int'(cardPullLow), 0);
    checkIdle("R2", 10);

    // directed transfers
    runXfer(1'b0, 12, 1'b0, 1'b0, "R3 R4 host master");
    runXfer(1'b1, 12, 1'b0, 1'b0, "R5 card master R10");
    runXfer(1'b0, D, 1'b0, 1'b0, "R8 low of EDGE_DLY edges");
    runXfer(1'b1, 1, 1'b0, 1'b0, "R8 single-edge glitch");
    runXfer(1'b0, D + 1, 1'b0, 1'b0, "R8 R3 boundary forwarded");
    runXfer(1'b0, D + 14, 1'b0, 1'b1, "R6 slave low during host transfer");
    runXfer(1'b1, D + 14, 1'b0, 1'b1, "R6 slave low during card transfer");
    runXfer(1'b0, 15, 1'b1, 1'b0, "R7 simultaneous falls");
    checkIdle("R2", 5);

    // R9 abort mid-transfer
    cardExt = 1'b0;
    repeat (D + 6) @(negedge clk);
    checkEq("R5", "host pulled low before abort", int'(hostPullLow), 1);
    sessEn = 1'b0;
    repeat (2) @(negedge clk);
    checkEq("R9", "host pull-low after abort", int'(hostPullLow), 0);
    checkEq("R9", "card pull-low after abort", int'(cardPullLow), 1);
    checkEq("R9", "pullups after abort", int'({hostPullUp, cardPullUp}), 0);
    hostExt = 1'b0;
    begin
      int bad = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (hostPullLow || hostPullUp || cardPullUp || !cardPullLow) bad++;
      end
      checkEq("R9", "host activity while disabled", bad, 0);
    end
    hostExt = 1'b1;
    cardExt = 1'b1;
    repeat (3) @(negedge clk);
    sessEn = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R10", 6);
    runXfer(1'b0, 10, 1'b0, 1'b0, "R10 re-armed after abort");

    // random transfers
    for (int k = 0; k < 40; k++) begin
      bit dir = 1'($urandom_range(0, 1));
      int len = int'($urandom_range(1, D + 20));
      runXfer(dir, len, 1'b0, 1'b0, "R10 random R3 R4 R5 R8");
      repeat (int'($urandom_range(0, 6))) @(negedge clk);
    end
    checkIdle("R2", 4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule